// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block watches the horizontal and vertical sync pulses of an interlaced video source and decides, once per field, whether the field that has just begun is odd or even. In an interlaced raster the vertical sync pulse lands at a different phase within the line in alternate fields. The block measures, in system clocks, how long after the latest horizontal sync the vertical sync arrives. It then compares that measurement with the one taken in the previous field.

The parity decision is held in a field flag. The flag feeds a dot-line selector, so an on-screen character generator can fetch one font dot row in one field and the neighbouring row in the next. This doubles the apparent vertical resolution of characters on an interlaced screen. A configuration input reverses the pairing between parity and dot row. A one-clock strobe marks every point at which the block makes a field decision.

Both sync inputs are active-low and asynchronous to the system clock. Each passes through a two-flop synchroniser before its edges are detected.

Top module: `fpd_field_detect`

## Requirements
- R1: While reset is asserted and after it is released, `field_odd` is 0 and `field_stb` is 0 until the first field decision.
- R2: When the sync-to-sync interval of a new field is longer than that of the previous field, `field_odd` becomes 0 (even field).
- R3: When the interval of a new field is shorter than that of the previous field, `field_odd` becomes 1 (odd field).
- R4: When the interval of a new field equals that of the previous field, as with a non-interlaced source, `field_odd` inverts.
- R5: The first field decision after reset leaves `field_odd` unchanged, because no earlier interval exists to compare with.
- R6: `field_odd` changes only at a field decision. A decision is taken on the trailing (rising) edge of `vsync_n`, and the new value appears at the third rising clock edge after that input change. A falling `vsync_n` alone never changes the flag.
- R7: `field_stb` is high for exactly one clock at each field decision, including the first one, and in the same cycle that `field_odd` takes its new value.
- R8: `dot_line` is the inverse of `field_odd` when `dot_sel` is 0, and equals `field_odd` when `dot_sel` is 1.
- R9: The interval counter is CNT_W bits wide (16 by default). It saturates at its all-ones value and never wraps, so two intervals that both reach that value compare equal.
- R10: The interval is measured from the most recent falling edge of `hsync_n` before the falling edge of `vsync_n`. Earlier horizontal pulses in the same field do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Horizontal sync, active low, asynchronous |
| vsync_n | input | 1 | Vertical sync, active low, asynchronous |
| dot_sel | input | 1 | Swaps the pairing between field parity and dot row |
| field_odd | output | 1 | Field flag: 1 for an odd field, 0 for an even field |
| dot_line | output | 1 | Font dot row index for the current field |
| field_stb | output | 1 | One-clock pulse at each field decision |

## Verification
Embedded properties watch, on every cycle, that the flag holds between decisions and that the strobe never lasts past one clock. They also check that the interval counter clears on a horizontal edge and sticks at its ceiling, and that each of the longer, shorter, equal and first-field cases drives the flag the right way. The bench scenarios alone show the end-to-end behaviour: the three-edge latency from the vsync input, the dot-row pairing under both settings of `dot_sel`, and the rejection of an earlier horizontal pulse in favour of the latest one. They also cover the saturation case, in which two very long intervals are treated as equal.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    // Default interval counter width
    parameter int unsigned FPD_CNT_W = 16;

    // Number of flip-flop stages in each sync input synchroniser
    parameter int unsigned FPD_SYNC_STAGES = 2;

    // Outcome of comparing a new field's interval with the stored one
    typedef enum logic [1:0] {
        CMP_FIRST   = 2'd0,  // nothing stored yet
        CMP_LONGER  = 2'd1,  // new interval longer  -> even
        CMP_SHORTER = 2'd2,  // new interval shorter -> odd
        CMP_EQUAL   = 2'd3   // equal (progressive)  -> invert
    } cmp_e;

endpackage

// File: rtl/fpd_sync.sv
module fpd_sync #(
    parameter int unsigned STAGES = fpd_pkg::FPD_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic fall_o,
    output logic rise_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[DEPTH-2:0], async_i};
    end

    // Inputs idle high, so reset to ones to avoid a false edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pipe: '1};
        else        st_q <= st_d;
    end

    assign level_o = st_q.pipe[STAGES-1];
    assign fall_o  =  st_q.pipe[STAGES] & ~st_q.pipe[STAGES-1];
    assign rise_o  = ~st_q.pipe[STAGES] &  st_q.pipe[STAGES-1];

endmodule

// File: rtl/fpd_interval.sv
module fpd_interval #(
    parameter int unsigned CNT_W = fpd_pkg::FPD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_fall_i,
    input  logic             vs_fall_i,
    output logic [CNT_W-1:0] meas_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] meas;
    } ivl_st_t;

    ivl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hs_fall_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (vs_fall_i) begin
            st_d.meas = st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign meas_o = st_q.meas;

    // R9: the counter sticks at its ceiling
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fall_i && st_q.cnt == CNT_MAX) |=> (st_q.cnt == CNT_MAX));

    // R10: each horizontal edge restarts the measurement
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        hs_fall_i |=> (st_q.cnt == '0));

endmodule

// File: rtl/fpd_classify.sv
module fpd_classify #(
    parameter int unsigned CNT_W = fpd_pkg::FPD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_rise_i,
    input  logic [CNT_W-1:0] meas_i,
    output logic             flag_o,
    output logic             strobe_o
);
    import fpd_pkg::*;

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] prev;
        logic             valid;
        logic             strobe;
    } cls_st_t;

    cls_st_t st_d, st_q;
    cmp_e    cmp;

    always_comb begin
        if (!st_q.valid)              cmp = CMP_FIRST;
        else if (meas_i > st_q.prev)  cmp = CMP_LONGER;
        else if (meas_i < st_q.prev)  cmp = CMP_SHORTER;
        else                          cmp = CMP_EQUAL;
    end

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (vs_rise_i) begin
            unique case (cmp)
                CMP_FIRST:   st_d.flag = st_q.flag;
                CMP_LONGER:  st_d.flag = 1'b0;
                CMP_SHORTER: st_d.flag = 1'b1;
                CMP_EQUAL:   st_d.flag = ~st_q.flag;
                default:     st_d.flag = st_q.flag;
            endcase
            st_d.prev   = meas_i;
            st_d.valid  = 1'b1;
            st_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o   = st_q.flag;
    assign strobe_o = st_q.strobe;

    // R6: the flag holds between decisions
    a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise_i |=> $stable(st_q.flag));

    // R7: the strobe lasts one clock
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |=> !st_q.strobe);

    // R5: the first decision keeps the flag
    a_r5_first_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_rise_i && !st_q.valid) |=> $stable(st_q.flag));

    // R2: a longer interval gives an even field
    a_r2_longer_even: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_rise_i && st_q.valid && meas_i > st_q.prev) |=> !st_q.flag);

    // R3: a shorter interval gives an odd field
    a_r3_shorter_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_rise_i && st_q.valid && meas_i < st_q.prev) |=> st_q.flag);

    // R4: an equal interval inverts the flag
    a_r4_equal_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_rise_i && st_q.valid && meas_i == st_q.prev)
            |=> (st_q.flag != $past(st_q.flag)));

endmodule

// File: rtl/fpd_field_detect.sv
module fpd_field_detect #(
    parameter int unsigned CNT_W       = fpd_pkg::FPD_CNT_W,
    parameter int unsigned SYNC_STAGES = fpd_pkg::FPD_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_n,
    input  logic vsync_n,
    input  logic dot_sel,
    output logic field_odd,
    output logic dot_line,
    output logic field_stb
);
    localparam int unsigned N_CH  = 2;
    localparam int unsigned CH_HS = 0;
    localparam int unsigned CH_VS = 1;

    logic [N_CH-1:0]  raw_in;
    logic [N_CH-1:0]  lvl;
    logic [N_CH-1:0]  fall;
    logic [N_CH-1:0]  rise;
    logic [CNT_W-1:0] meas;
    logic             flag;

    assign raw_in[CH_HS] = hsync_n;
    assign raw_in[CH_VS] = vsync_n;

    for (genvar g = 0; g < N_CH; g++) begin : g_sync
        fpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_in[g]),
            .level_o (lvl[g]),
            .fall_o  (fall[g]),
            .rise_o  (rise[g])
        );
    end

    fpd_interval #(.CNT_W(CNT_W)) u_interval (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_fall_i (fall[CH_HS]),
        .vs_fall_i (fall[CH_VS]),
        .meas_o    (meas)
    );

    fpd_classify #(.CNT_W(CNT_W)) u_classify (
        .clk       (clk),
        .rst_n     (rst_n),
        .vs_rise_i (rise[CH_VS]),
        .meas_i    (meas),
        .flag_o    (flag),
        .strobe_o  (field_stb)
    );

    assign field_odd = flag;
    assign dot_line  = ~(flag ^ dot_sel);

    // R6: no decision while vertical sync is held low
    a_r6_no_change_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl[CH_VS] && $past(!lvl[CH_VS])) |-> !field_stb);

endmodule

// File: tb/fpd_field_detect_tb.sv
module fpd_field_detect_tb;

    localparam int unsigned CNT_W  = 16;
    localparam int          SATMAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_n = 1'b1;
    logic vsync_n = 1'b1;
    logic dot_sel = 1'b0;
    logic field_odd, dot_line, field_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    bit exp_flag = 1'b0;
    int prev_m = 0;
    bit prev_ok = 1'b0;

    always #5 clk = ~clk;

    fpd_field_detect #(.CNT_W(CNT_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_n   (hsync_n),
        .vsync_n   (vsync_n),
        .dot_sel   (dot_sel),
        .field_odd (field_odd),
        .dot_line  (dot_line),
        .field_stb (field_stb)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_dot(bit f, bit s);
        return s ? f : ~f;
    endfunction

    function automatic int measure(int delta);
        int m = delta - 1;
        return (m > SATMAX) ? SATMAX : m;
    endfunction

    function automatic bit decide(bit old, bit ok, int prev, int now);
        if (!ok)        return old;
        if (now > prev) return 1'b0;
        if (now < prev) return 1'b1;
        return ~old;
    endfunction

    // One field: optional early hsync, then hsync, then vsync delta clocks later
    task automatic run_field(int delta, int extra_gap, bit sel, string req);
        bit old;
        int m;
        old = exp_flag;
        m = measure(delta);
        exp_flag = decide(old, prev_ok, prev_m, m);
        prev_m = m;
        prev_ok = 1'b1;
        @(negedge clk);
        dot_sel = sel;
        if (extra_gap > 0) begin
            hsync_n = 1'b0;
            repeat (2) @(negedge clk);
            hsync_n = 1'b1;
            repeat (extra_gap) @(negedge clk);
        end
        hsync_n = 1'b0;
        for (int i = 1; i <= delta; i++) begin
            @(negedge clk);
            if (i == 2) hsync_n = 1'b1;
        end
        vsync_n = 1'b0;
        repeat (4) @(negedge clk);
        chk({req, " R6 flag held during vsync"}, field_odd, old);
        vsync_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({req, " R6 flag before third edge"}, field_odd, old);
        chk({req, " R7 no early strobe"}, field_stb, 0);
        @(negedge clk);
        chk({req, " flag decision"}, field_odd, exp_flag);
        chk({req, " R7 strobe with update"}, field_stb, 1);
        chk({req, " R8 dot line"}, dot_line, exp_dot(exp_flag, sel));
        @(negedge clk);
        chk({req, " R7 strobe one clock"}, field_stb, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL R6 watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 flag in reset", field_odd, 0);
        chk("R1 strobe in reset", field_stb, 0);
        chk("R8 dot in reset sel0", dot_line, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 flag after reset", field_odd, 0);
        chk("R1 strobe after reset", field_stb, 0);

        run_field(100, 0, 1'b0, "R5 first field");
        run_field(150, 0, 1'b1, "R2 longer");
        run_field(120, 0, 1'b0, "R3 shorter");
        run_field(120, 0, 1'b1, "R4 equal a");
        run_field(120, 0, 1'b0, "R4 equal b");
        run_field(80, 500, 1'b1, "R10 latest hsync");
        run_field(90, 40, 1'b0, "R10 latest hsync b");

        for (int k = 0; k < 24; k++) begin
            int d;
            d = 3 + int'($urandom_range(0, 400));
            if (k % 5 == 4) d = prev_m + 1;
            run_field(d, 0, 1'($urandom_range(0, 1)), "R2/R3/R4 random");
        end

        // R9: make the flag 1, then two saturating intervals compare equal
        run_field(300, 0, 1'b0, "R9 setup a");
        run_field(200, 0, 1'b0, "R9 setup b");
        chk("R9 setup flag odd", field_odd, 1);
        run_field(65600, 0, 1'b0, "R9 saturate a");
        run_field(65540, 0, 1'b1, "R9 saturate equal");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule